// File: doc/BRIEF.md
# Configurable Wake-Up Event Router

The block watches seven asynchronous event lines and records each occurrence in a sticky status bit. The lines are, in bit order 0 to 6: general wake-up lines A, B, C and D, the alarm timer, the real-time clock and the supply-voltage monitor. Each line is brought into the clock domain by a two-flop synchronizer. It is then qualified either as a level, active high or active low, or as an edge, rising or falling, according to two configuration registers.

An enable mask selects which status bits may drive the single interrupt request output. Software reaches the block over a small synchronous register port. The port has an 8-bit address, 32-bit data, a one-cycle write strobe and combinational read data. Status bits are cleared by writing ones to a dedicated clear address.

The clear behaviour depends on the detect mode. A bit qualified by level keeps re-asserting while its line is still at the active level, so software cannot clear it early. A bit qualified by edge clears as soon as software asks.

Top module: `evt_router`

## Requirements
- R1: Line k (k = 0..6) sets only status bit k. Bit order is wake-up A, B, C, D, alarm timer, real-time clock, voltage monitor.
- R2: In the mode register, a 0 in bit k selects level detection for line k and a 1 selects edge detection.
- R3: In level mode, polarity bit k = 0 makes a low line active and polarity bit k = 1 makes a high line active. An inactive line never sets status.
- R4: In edge mode, polarity bit k = 0 detects a falling edge and polarity bit k = 1 detects a rising edge. The opposite edge and a steady level do not set status.
- R5: In level mode, a clear has no effect while the line is still active. After the line returns to the inactive level, the bit stays latched until it is cleared, and the clear then takes effect.
- R6: In edge mode, a clear written in any cycle after the detection takes effect, even though the line remains at its post-edge level.
- R7: When a detection and a clear of the same bit fall on the same clock edge, the bit stays set.
- R8: The irq output is high exactly when some status bit and its enable bit are both 1.
- R9: A line change becomes visible in status and irq after the third rising clock edge that follows it, and not after the second.
- R10: The register map is 0x00 mode, 0x04 polarity, 0x08 enable, 0x0C status (read-only), and 0x10 clear (write-1-to-clear, reads 0). Bits 31..7 and unmapped addresses read 0. Writes to 0x0C are ignored.
- R11: Reset clears mode, polarity, enable and status to 0 and holds irq low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 7 | Asynchronous event lines, bit k = line k |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: seven lines, an 8-bit address and 32-bit data. At this size every line can be swept through every pairing of detect mode and polarity. For each combination the bench checks the idle state, the exact latency, the set bit, the clear-while-active rule or the immediate clear, and the masked and unmasked interrupt. The same-edge collision between a detection and a clear is placed deliberately. Register readback and the unmapped addresses are checked as well.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam logic [7:0] ADR_MODE = 8'h00;
    localparam logic [7:0] ADR_POL  = 8'h04;
    localparam logic [7:0] ADR_EN   = 8'h08;
    localparam logic [7:0] ADR_STAT = 8'h0C;
    localparam logic [7:0] ADR_CLR  = 8'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_POL,
        SEL_EN,
        SEL_STAT,
        SEL_CLR
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [7:0] a);
        case (a)
            ADR_MODE: return SEL_MODE;
            ADR_POL:  return SEL_POL;
            ADR_EN:   return SEL_EN;
            ADR_STAT: return SEL_STAT;
            ADR_CLR:  return SEL_CLR;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] cur,
    output logic [N-1:0] prev
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] stab;
        logic [N-1:0] last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw;
        st_d.stab = st_q.meta;
        st_d.last = st_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur  = st_q.stab;
    assign prev = st_q.last;

endmodule

// File: rtl/evt_detect.sv
module evt_detect #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] mode,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] clr,
    output logic [N-1:0] stat
);
    typedef struct packed {
        logic [N-1:0] stat;
    } det_t;

    det_t         st_d, st_q;
    logic [N-1:0] hit;

    for (genvar k = 0; k < N; k++) begin : g_src
        logic lvl_act;
        logic edg_act;
        always_comb begin
            lvl_act = pol[k] ? cur[k] : ~cur[k];
            edg_act = pol[k] ? (cur[k] & ~prev[k]) : (~cur[k] & prev[k]);
            hit[k]  = mode[k] ? edg_act : lvl_act;
        end

        // R7: a detection always lands in status, even against a clear
        p_detect_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            hit[k] |=> stat[k]);

        // R6: a clear with no detection empties the bit next cycle
        p_clear_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[k] && !hit[k]) |=> !stat[k]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.stat = hit | (st_q.stat & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;

endmodule

// File: rtl/evt_regs.sv
module evt_regs
    import evt_pkg::*;
#(
    parameter int N  = 7,
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [N-1:0]  stat,
    output logic [DW-1:0] rdata,
    output logic [N-1:0]  mode,
    output logic [N-1:0]  pol,
    output logic [N-1:0]  clr,
    output logic          irq
);
    localparam int PAD = DW - N;

    typedef struct packed {
        logic [N-1:0] mode;
        logic [N-1:0] pol;
        logic [N-1:0] en;
    } cfg_t;

    cfg_t         st_d, st_q;
    reg_sel_e     sel;
    logic [N-1:0] wbits;
    logic [N-1:0] rsel;
    logic         unused_hi;

    assign sel       = decode_addr(8'(addr));
    assign wbits     = wdata[N-1:0];
    assign unused_hi = ^wdata[DW-1:N];

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (wr) begin
            case (sel)
                SEL_MODE: st_d.mode = wbits;
                SEL_POL:  st_d.pol  = wbits;
                SEL_EN:   st_d.en   = wbits;
                SEL_CLR:  clr       = wbits;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_MODE: rsel = st_q.mode;
            SEL_POL:  rsel = st_q.pol;
            SEL_EN:   rsel = st_q.en;
            SEL_STAT: rsel = stat;
            default:  rsel = '0;
        endcase
        rdata = {{PAD{1'b0}}, rsel};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode = st_q.mode;
    assign pol  = st_q.pol;
    assign irq  = |(stat & st_q.en);

    // R10: configuration only moves on a write strobe
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(st_q));

    // R10: unmapped and clear addresses read zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE || sel == SEL_CLR) |-> rdata == '0);

    // R8: with every enable low the request stays low
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en == '0) |-> !irq);

endmodule

// File: rtl/evt_router.sv
module evt_router #(
    parameter int N  = 7,
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  evt_in,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    logic [N-1:0] cur, prev, mode, pol, clr, stat;

    evt_sync #(.N(N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (evt_in),
        .cur  (cur),
        .prev (prev)
    );

    evt_detect #(.N(N)) u_det (
        .clk  (clk),
        .rst_n(rst_n),
        .cur  (cur),
        .prev (prev),
        .mode (mode),
        .pol  (pol),
        .clr  (clr),
        .stat (stat)
    );

    evt_regs #(.N(N), .AW(AW), .DW(DW)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (bus_addr),
        .wr   (bus_wr),
        .wdata(bus_wdata),
        .stat (stat),
        .rdata(bus_rdata),
        .mode (mode),
        .pol  (pol),
        .clr  (clr),
        .irq  (irq)
    );

endmodule

// File: tb/tb_evt_router.sv
module tb_evt_router;
    localparam int N = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt_in = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    evt_router dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_in),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    logic [31:0] v;

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wcyc(3);
        // R11: reset values, read while reset is held
        rd(8'h00, v); chk("R11 mode reset", v, 0);
        rd(8'h04, v); chk("R11 pol reset", v, 0);
        rd(8'h08, v); chk("R11 en reset", v, 0);
        rd(8'h0C, v); chk("R11 stat reset", v, 0);
        chk("R11 irq reset", {31'b0, irq}, 0);
        rst_n = 1'b1;

        // R3: default polarity 0 makes low lines active
        wcyc(4);
        rd(8'h0C, v); chk("R3 active-low default", v, 32'h7F);
        chk("R8 irq masked", {31'b0, irq}, 0);

        // R10: register map and unused bits
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R10 mode width", v, 32'h7F);
        wr(8'h00, 32'h0);
        rd(8'h10, v); chk("R10 clear reads 0", v, 0);
        rd(8'h14, v); chk("R10 unmapped", v, 0);
        rd(8'h0D, v); chk("R10 unmapped odd", v, 0);
        wr(8'h0C, 32'h0);
        rd(8'h0C, v); chk("R10 status read-only", v, 32'h7F);

        for (int i = 0; i < N; i++) begin
            for (int m = 0; m < 2; m++) begin
                for (int p = 0; p < 2; p++) begin
                    logic [6:0] b;
                    string tg;
                    b  = 7'(1 << i);
                    tg = $sformatf("src%0d m%0d p%0d", i, m, p);
                    wr(8'h00, m ? {25'b0, b} : 32'h0);
                    wr(8'h04, p ? 32'h7F : {25'b0, 7'h7F & ~b});
                    wr(8'h08, {25'b0, b});
                    evt_in = p ? 7'h00 : b;
                    wcyc(4);
                    wr(8'h10, 32'h7F);
                    rd(8'h0C, v); chk({"R3 R4 idle ", tg}, v, 0);
                    chk({"R8 idle irq ", tg}, {31'b0, irq}, 0);
                    evt_in[i] = p[0];
                    wcyc(2);
                    rd(8'h0C, v); chk({"R9 not yet ", tg}, v, 0);
                    wcyc(1);
                    rd(8'h0C, v); chk({"R1 R2 set ", tg}, v, {25'b0, b});
                    chk({"R8 irq on ", tg}, {31'b0, irq}, 1);
                    if (m == 0) begin
                        wr(8'h10, 32'h7F);
                        rd(8'h0C, v); chk({"R5 hold active ", tg}, v, {25'b0, b});
                        wr(8'h08, 32'h0);
                        chk({"R8 irq masked ", tg}, {31'b0, irq}, 0);
                        evt_in[i] = ~p[0];
                        wcyc(4);
                        rd(8'h0C, v); chk({"R5 latched ", tg}, v, {25'b0, b});
                        wr(8'h10, {25'b0, b});
                        rd(8'h0C, v); chk({"R5 cleared ", tg}, v, 0);
                    end else begin
                        wr(8'h10, {25'b0, b});
                        rd(8'h0C, v); chk({"R6 edge clear ", tg}, v, 0);
                        wcyc(4);
                        rd(8'h0C, v); chk({"R4 steady ", tg}, v, 0);
                        evt_in[i] = ~p[0];
                        wcyc(4);
                        rd(8'h0C, v); chk({"R4 opposite edge ", tg}, v, 0);
                    end
                end
            end
        end

        // R7: rising edge on line 0 detected on the same edge as a clear
        wr(8'h00, 32'h01);
        wr(8'h04, 32'h7F);
        evt_in = 7'h00;
        wcyc(4);
        wr(8'h10, 32'h7F);
        evt_in[0] = 1'b1;
        wcyc(2);
        wr(8'h10, 32'h01);
        rd(8'h0C, v); chk("R7 detect beats clear", v, 32'h01);
        wr(8'h10, 32'h01);
        rd(8'h0C, v); chk("R6 later clear", v, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule